// File: doc/BRIEF.md
# Pipelined Synchronous Burst Memory Cycle Decoder

This block sits at the control front of a synchronous burst memory. Each enabled clock edge it samples the per-cycle control inputs and names the cycle: a deselect, a continued deselect, a read that starts or continues a burst, a dummy read that starts or continues a burst, a write, or a wait. A single load/advance input selects between starting a new burst and continuing the current one. Because of this, the block keeps a small record of the kind of burst in progress. A continue cycle then takes on that kind, and a run of deselects counts as a kind of its own.

The decoded cycle type is registered and held as a 3-bit code. The data-bus drive enable is computed without a clock from that registered code and the live output-enable pin. The bus is driven only after a real read, and only while output enable is low. A write cycle never drives the bus.

A sleep request is asynchronous. It passes through a short synchronizer and then forces the block into a deselected state with no burst in progress. The memory array, the burst address counter and the data pipeline registers are not part of this block.

Top module: `burst_cycle_decoder`

## Requirements
- R1: During reset and after it, until the first enabled edge, the cycle type is 0 (deselect) and the bus is not driven, whatever the level of output enable.
- R2: An enabled edge with load_n low and sel_all low registers type 0 (deselect).
- R3: An enabled edge with load_n high, while the burst in progress is a deselect, registers type 1 (continued deselect). The value of sel_all is ignored on such a cycle.
- R4: An enabled edge with load_n low, sel_all high, wr_n high and oe_n low registers type 2 (read begin). A later advance (load_n high) with oe_n low registers type 3 (read continue), whatever sel_all is. The bus is driven after both.
- R5: A read begin or read continue whose oe_n is high at the edge registers type 4 (dummy begin) or type 5 (dummy continue), and the bus stays released.
- R6: An edge with clk_en_n high registers type 7 (wait) and leaves the burst in progress unchanged, so the next advance continues the earlier burst.
- R7: An enabled edge with load_n low, sel_all high and wr_n low registers type 6 (write). An advance after it also gives type 6. The bus is never driven for type 6, even with oe_n low.
- R8: bus_drv responds to oe_n within the same cycle, with no clock edge needed, while the registered type is 2 or 3.
- R9: Once sleep_in has passed SYNC_STAGES synchronizer flops, every edge registers type 0 and clears the burst in progress. This holds even when clk_en_n is high. After wake-up, the first advance gives type 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_all | input | 1 | High when every chip enable is active |
| load_n | input | 1 | Low: start a burst; high: advance the current one |
| wr_n | input | 1 | Low requests a write on a load cycle |
| oe_n | input | 1 | Active-low output enable, not sampled for bus drive |
| clk_en_n | input | 1 | High inserts a wait cycle |
| sleep_in | input | 1 | Asynchronous sleep request |
| cyc_type | output | 3 | Registered cycle-type code |
| bus_drv | output | 1 | Data bus drive enable |

## Verification
The cycle type is due one edge after the inputs that set it. The bench drives those inputs on the falling edge and compares the queued expected code shortly after the following rising edge. bus_drv carries no latency from oe_n, so it is checked a fraction of a nanosecond after oe_n is toggled within the same cycle. A sleep change takes effect on the third edge after it is applied: two synchronizer edges, then the decode edge. The expected codes on that path are queued so that the two edges before it still show normal decode.

// File: rtl/cyc_dec_pkg.sv
package cyc_dec_pkg;
   typedef enum logic [2:0] {
      CYC_DESEL       = 3'd0,
      CYC_DESEL_CONT  = 3'd1,
      CYC_RD_BEGIN    = 3'd2,
      CYC_RD_CONT     = 3'd3,
      CYC_DUMMY_BEGIN = 3'd4,
      CYC_DUMMY_CONT  = 3'd5,
      CYC_WRITE       = 3'd6,
      CYC_WAIT        = 3'd7
   } cyc_t;

   typedef enum logic [1:0] {
      BK_NONE  = 2'd0,
      BK_READ  = 2'd1,
      BK_WRITE = 2'd2
   } burst_t;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] stage;

   if (STAGES < 2) begin : g_bad_depth
      $error("sleep_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[0] <= 1'b0;
            else        stage[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= 1'b0;
            else        stage[i] <= stage[i-1];
         end
      end
   end

   assign q = stage[LAST];
endmodule

// File: rtl/cyc_classify.sv
module cyc_classify
   import cyc_dec_pkg::*;
(
   input  logic   sel_all,
   input  logic   load_n,
   input  logic   wr_n,
   input  logic   oe_n,
   input  logic   clk_en_n,
   input  logic   asleep,
   input  burst_t kind_q,
   output cyc_t   nxt_type,
   output burst_t nxt_kind
);
   always_comb begin
      nxt_type = CYC_DESEL;
      nxt_kind = kind_q;
      if (asleep) begin
         nxt_type = CYC_DESEL;
         nxt_kind = BK_NONE;
      end else if (clk_en_n) begin
         nxt_type = CYC_WAIT;
      end else if (!load_n) begin
         if (!sel_all) begin
            nxt_type = CYC_DESEL;
            nxt_kind = BK_NONE;
         end else if (!wr_n) begin
            nxt_type = CYC_WRITE;
            nxt_kind = BK_WRITE;
         end else begin
            nxt_type = oe_n ? CYC_DUMMY_BEGIN : CYC_RD_BEGIN;
            nxt_kind = BK_READ;
         end
      end else begin
         unique case (kind_q)
            BK_READ:  nxt_type = oe_n ? CYC_DUMMY_CONT : CYC_RD_CONT;
            BK_WRITE: nxt_type = CYC_WRITE;
            default:  nxt_type = CYC_DESEL_CONT;
         endcase
      end
   end
endmodule

// File: rtl/burst_cycle_decoder.sv
module burst_cycle_decoder
   import cyc_dec_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_all,
   input  logic       load_n,
   input  logic       wr_n,
   input  logic       oe_n,
   input  logic       clk_en_n,
   input  logic       sleep_in,
   output logic [2:0] cyc_type,
   output logic       bus_drv
);
   logic   sleep_s;
   cyc_t   type_q, nxt_type;
   burst_t kind_q, nxt_kind;

   sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sleep_in),
      .q     (sleep_s)
   );

   cyc_classify u_cls (
      .sel_all  (sel_all),
      .load_n   (load_n),
      .wr_n     (wr_n),
      .oe_n     (oe_n),
      .clk_en_n (clk_en_n),
      .asleep   (sleep_s),
      .kind_q   (kind_q),
      .nxt_type (nxt_type),
      .nxt_kind (nxt_kind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q <= CYC_DESEL;
         kind_q <= BK_NONE;
      end else begin
         type_q <= nxt_type;
         kind_q <= nxt_kind;
      end
   end

   assign cyc_type = type_q;
   assign bus_drv  = ((type_q == CYC_RD_BEGIN) || (type_q == CYC_RD_CONT)) && !oe_n;
endmodule

// File: rtl/burst_cycle_decoder_chk.sv
module burst_cycle_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_all,
   input logic       load_n,
   input logic       wr_n,
   input logic       oe_n,
   input logic       clk_en_n,
   input logic       sleep_s,
   input logic [2:0] cyc_type,
   input logic       bus_drv
);
   AST_DESEL_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !load_n && !sel_all && !sleep_s) |=> (cyc_type == 3'd0)); // R2
   AST_READ_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !load_n && sel_all && wr_n && !oe_n && !sleep_s) |=> (cyc_type == 3'd2)); // R4
   AST_WAIT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_n && !sleep_s) |=> (cyc_type == 3'd7)); // R6
   AST_WRITE_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !load_n && sel_all && !wr_n && !sleep_s) |=> (cyc_type == 3'd6)); // R7
   AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drv |-> !oe_n); // R8
   AST_SLEEP_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_s |=> (cyc_type == 3'd0)); // R9
endmodule

bind burst_cycle_decoder burst_cycle_decoder_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_all  (sel_all),
   .load_n   (load_n),
   .wr_n     (wr_n),
   .oe_n     (oe_n),
   .clk_en_n (clk_en_n),
   .sleep_s  (sleep_s),
   .cyc_type (cyc_type),
   .bus_drv  (bus_drv)
);

// File: tb/burst_cycle_decoder_tb_top.sv
`timescale 1ns/100ps
module burst_cycle_decoder_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_all = 1'b0, load_n = 1'b0, wr_n = 1'b1, oe_n = 1'b0;
   logic clk_en_n = 1'b0, sleep_in = 1'b0;
   logic [2:0] cyc_type;
   logic bus_drv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [2:0] exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   burst_cycle_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .sel_all(sel_all), .load_n(load_n), .wr_n(wr_n),
      .oe_n(oe_n), .clk_en_n(clk_en_n), .sleep_in(sleep_in),
      .cyc_type(cyc_type), .bus_drv(bus_drv)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: apply one cycle of inputs and queue the type expected after the next edge
   task automatic step(input logic s, input logic ld, input logic w, input logic o,
                       input logic ce, input logic sl, input logic [2:0] e, input string req);
      @(negedge clk);
      sel_all = s; load_n = ld; wr_n = w; oe_n = o; clk_en_n = ce; sleep_in = sl;
      exp_q.push_back(e);
      tag_q.push_back(req);
      @(posedge clk);
      #1.2;
   endtask

   // monitor: compare each queued item shortly after the edge it belongs to
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         automatic logic [2:0] e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         check(cyc_type === e, t, int'(cyc_type), int'(e));
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cyc_type === 3'd0, "R1 reset type", int'(cyc_type), 0);
      check(bus_drv === 1'b0, "R1 reset drive", int'(bus_drv), 0);
      rst_n = 1'b1;
      clk_en_n = 1'b1;
      @(negedge clk);
      check(bus_drv === 1'b0, "R1 after release", int'(bus_drv), 0);
      //   sel ld  wr  oe  ce  sl
      step(0, 0, 1, 0, 0, 0, 3'd0, "R2 deselect");
      step(1, 1, 1, 0, 0, 0, 3'd1, "R3 continue deselect");
      step(0, 1, 0, 0, 0, 0, 3'd1, "R3 continue deselect again");
      step(1, 0, 1, 0, 0, 0, 3'd2, "R4 read begin");
      check(bus_drv === 1'b1, "R4 drive on read", int'(bus_drv), 1);
      oe_n = 1'b1; #0.3;
      check(bus_drv === 1'b0, "R8 oe high releases", int'(bus_drv), 0);
      oe_n = 1'b0; #0.3;
      check(bus_drv === 1'b1, "R8 oe low drives", int'(bus_drv), 1);
      step(0, 1, 1, 0, 0, 0, 3'd3, "R4 read continue");
      check(bus_drv === 1'b1, "R4 drive on continue", int'(bus_drv), 1);
      step(1, 1, 1, 1, 0, 0, 3'd5, "R5 dummy continue");
      check(bus_drv === 1'b0, "R5 dummy continue released", int'(bus_drv), 0);
      step(1, 0, 1, 1, 0, 0, 3'd4, "R5 dummy begin");
      oe_n = 1'b0; #0.3;
      check(bus_drv === 1'b0, "R5 dummy begin released", int'(bus_drv), 0);
      step(0, 0, 0, 0, 1, 0, 3'd7, "R6 wait");
      check(bus_drv === 1'b0, "R6 wait released", int'(bus_drv), 0);
      step(0, 1, 1, 0, 0, 0, 3'd3, "R6 advance after wait keeps read");
      step(1, 0, 0, 0, 0, 0, 3'd6, "R7 write begin");
      check(bus_drv === 1'b0, "R7 write masks oe", int'(bus_drv), 0);
      step(0, 1, 1, 0, 0, 0, 3'd6, "R7 write continue");
      check(bus_drv === 1'b0, "R7 write continue masks oe", int'(bus_drv), 0);
      step(0, 1, 1, 0, 1, 0, 3'd7, "R6 wait in write");
      step(0, 1, 1, 0, 0, 0, 3'd6, "R6 advance after wait keeps write");
      step(1, 0, 1, 0, 0, 0, 3'd2, "R4 read begin before sleep");
      step(0, 1, 1, 0, 0, 1, 3'd3, "R9 sleep stage one");
      step(0, 1, 1, 0, 0, 1, 3'd3, "R9 sleep stage two");
      step(0, 1, 1, 0, 0, 1, 3'd0, "R9 asleep");
      check(bus_drv === 1'b0, "R9 asleep released", int'(bus_drv), 0);
      step(1, 0, 1, 0, 1, 1, 3'd0, "R9 sleep beats wait and load");
      step(0, 1, 1, 0, 0, 0, 3'd0, "R9 wake stage one");
      step(0, 1, 1, 0, 0, 0, 3'd0, "R9 wake stage two");
      step(0, 1, 1, 0, 0, 0, 3'd1, "R9 burst cleared by sleep");
      @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule